// File: doc/BRIEF.md
# Address Decode and Strobe Glue for a 65xx Bus

This block is the purely combinational glue between a 65C02-style processor and four devices: one ROM, one SRAM and two 65C22-style peripheral chips. It looks at the four highest address bits and drives one active-low select for each device. At most one select is active at a time, and all selects stay high in the unmapped hole. The selects come from the address alone. Each device therefore wakes up as soon as the address settles and has the whole address-valid time to prepare.

The block also produces two strobes that the ROM and the SRAM share: an active-low read strobe and an active-low write strobe. The read strobe follows the read/write line directly. On this bus a read needs no clock qualification. The write strobe is asserted only during phase-2 high. This keeps an unsettled address from causing a stray write. The two strobes are never asserted together.

The memory map is as follows. SRAM covers 0x0000–0x3FFF. 0x4000–0x5FFF is left free. Peripheral 1 covers 0x6000–0x6FFF and peripheral 2 covers 0x7000–0x7FFF. The ROM fills 0x8000–0xFFFF. Each peripheral's second, active-high select is tied high on the board.

Top module: `bus_glue`

## Requirements
- R1: `rom_cs_n` is low exactly when address bit 15 (`addr_hi[3]`) is 1.
- R2: `ram_cs_n` is low exactly when address bits 15 and 14 (`addr_hi[3:2]`) are both 0.
- R3: `per_cs_n[0]` is low exactly when `addr_hi` equals 4'b0110 (0x6000–0x6FFF).
- R4: `per_cs_n[1]` is low exactly when `addr_hi` equals 4'b0111 (0x7000–0x7FFF).
- R5: For `addr_hi` of 4'b0100 or 4'b0101, every select output is high.
- R6: No select output changes with `rnw` or `phi2`. For a fixed address, all four combinations of those two inputs give the same selects.
- R7: `rd_n` is low exactly when `rnw` is 1 (read), whatever the value of `phi2`.
- R8: `wr_n` is low exactly when `rnw` is 0 and `phi2` is 1.
- R9: `rd_n` and `wr_n` are never both low.
- R10: At most one of `rom_cs_n`, `ram_cs_n` and `per_cs_n` is low for any input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_hi | input | DEC_BITS (4) | Address bits 15..12 |
| rnw | input | 1 | Read/write line, 1 = read |
| phi2 | input | 1 | Phase-2 clock |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | SRAM select, active low |
| per_cs_n | output | NUM_PERIPH (2) | Peripheral selects, active low; bit 0 = 0x6000 window |
| rd_n | output | 1 | Shared read strobe, active low |
| wr_n | output | 1 | Shared write strobe, active low, qualified by phase-2 |

## Verification
The bench builds the block with its default parameters: four decoded address bits, two peripherals and a first peripheral window at 0x6. With these values the whole input space is only 64 combinations, so the bench visits every one. It does so twice, once in ascending order and once in descending order, so that each output is seen both rising and falling at every region boundary. With the address held fixed, the bench also steps through all four read/write and phase-2 combinations. This shows that the selects ignore the clock phase and that the strobes never overlap.

// File: rtl/bus_glue.sv
module bus_glue #(
  parameter int DEC_BITS    = 4,
  parameter int NUM_PERIPH  = 2,
  parameter int PERIPH_BASE = 6
) (
  input  logic [DEC_BITS-1:0]   addr_hi,
  input  logic                  rnw,
  input  logic                  phi2,
  output logic                  rom_cs_n,
  output logic                  ram_cs_n,
  output logic [NUM_PERIPH-1:0] per_cs_n,
  output logic                  rd_n,
  output logic                  wr_n
);
  localparam int TOP = DEC_BITS - 1;

  // Selects are decoded from address only; never from phi2 or rnw.
  assign rom_cs_n = ~addr_hi[TOP];
  assign ram_cs_n = addr_hi[TOP] | addr_hi[TOP-1];

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_per
    localparam logic [DEC_BITS-1:0] WIN = DEC_BITS'(PERIPH_BASE + g);
    assign per_cs_n[g] = (addr_hi != WIN);
  end

  assign rd_n = ~rnw;
  assign wr_n = rnw | ~phi2;

  always_comb begin
    AST_STROBE_EXCL: assert (rd_n | wr_n);                                  // R9
    AST_ONE_SELECT: assert ($countones({~rom_cs_n, ~ram_cs_n, ~per_cs_n}) <= 1); // R10
    if (!wr_n) AST_WR_IN_PHASE2: assert (phi2 && !rnw);                     // R8
    if (!rom_cs_n) AST_ROM_UPPER: assert (addr_hi[TOP]);                    // R1
    if (!ram_cs_n) AST_RAM_LOWER: assert (!addr_hi[TOP] && !addr_hi[TOP-1]); // R2
    if (!per_cs_n[0]) AST_PER0_WIN: assert (addr_hi == DEC_BITS'(PERIPH_BASE)); // R3
  end
endmodule

// File: tb/bus_glue_test.sv
module bus_glue_test;
  logic       clk = 1'b0;
  logic [3:0] addr_hi = 4'h0;
  logic       rnw = 1'b1;
  logic       phi2 = 1'b0;
  logic       rom_cs_n, ram_cs_n, rd_n, wr_n;
  logic [1:0] per_cs_n;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_glue uut (
    .addr_hi(addr_hi), .rnw(rnw), .phi2(phi2),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .per_cs_n(per_cs_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d addr=%h rnw=%0d phi2=%0d",
               req, act, exp, addr_hi, rnw, phi2);
    end
  endtask

  // behavioural reference: full 16-bit address ranges
  task automatic compare(input bit [4:0] ref_sel);
    int a;
    bit rom_e, ram_e, p0_e, p1_e;
    a = int'(addr_hi) * 4096;
    rom_e = (a >= 32'h8000);
    ram_e = (a < 32'h4000);
    p0_e  = (a >= 32'h6000) && (a < 32'h7000);
    p1_e  = (a >= 32'h7000) && (a < 32'h8000);
    chk("R1", int'(rom_cs_n), int'(!rom_e));
    chk("R2", int'(ram_cs_n), int'(!ram_e));
    chk("R3", int'(per_cs_n[0]), int'(!p0_e));
    chk("R4", int'(per_cs_n[1]), int'(!p1_e));
    if (a >= 32'h4000 && a < 32'h6000)
      chk("R5", int'({rom_cs_n, ram_cs_n, per_cs_n}), 15);
    chk("R6", int'({rom_cs_n, ram_cs_n, per_cs_n}), int'(ref_sel[3:0]));
    chk("R7", int'(rd_n), rnw ? 0 : 1);
    chk("R8", int'(wr_n), (!rnw && phi2) ? 0 : 1);
    chk("R9", int'(!rd_n && !wr_n), 0);
    chk("R10", ((!rom_cs_n) ? 1 : 0) + ((!ram_cs_n) ? 1 : 0) +
               ((!per_cs_n[0]) ? 1 : 0) + ((!per_cs_n[1]) ? 1 : 0) <= 1 ? 1 : 0, 1);
  endtask

  task automatic sweep(input bit down);
    for (int i = 0; i < 16; i++) begin
      bit [4:0] ref_sel;
      ref_sel = 5'h0;
      for (int c = 0; c < 4; c++) begin
        @(posedge clk);
        addr_hi = down ? 4'(15 - i) : 4'(i);
        rnw  = c[0] ? 1'b0 : 1'b1;
        phi2 = c[1];
        @(negedge clk);
        if (c == 0) ref_sel = {1'b0, rom_cs_n, ram_cs_n, per_cs_n};
        compare(ref_sel);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // idle state: address 0, read, phase-2 low
    @(negedge clk);
    chk("R2", int'(ram_cs_n), 0);
    chk("R7", int'(rd_n), 0);
    chk("R8", int'(wr_n), 1);
    sweep(1'b0);
    sweep(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule